// File: doc/BRIEF.md
# DMA Burst Read Engine

This block is the device side of a multiword DMA read burst on a 16-bit ATA-style bus. Each burst starts from a transfer count offered on a small valid/ready port. The engine then pulls the first data word from a valid/ready word stream. It raises the DMA request and waits for the host to pull the active-low acknowledge low. After that it serves one word per host read strobe.

The read strobe and the acknowledge come from the host asynchronously, so both pass through a synchronizer chain before the control logic sees them. On each low phase of the strobe the engine drives the held word onto the data lines and fetches the following word. When the strobe rises it tests the remaining count. The count is decremented between words, and the burst ends when the count reaches zero at a strobe rise. The engine then drops the request, waits for the acknowledge to return high, and pulses a done flag.

Top module: `dmard_engine`

## Requirements
- R1: After reset, `dmarq`, `dd_oe`, `phase` and `done` are low and `cnt_ready` is high.
- R2: A count is taken only when the engine is idle. Once the count is taken, `dmarq` stays low until the first data word has been accepted from the stream.
- R3: `dmarq` rises after the first word is held. It stays high until the final word's strobe has risen again, and it is low afterwards.
- R4: `dd_oe` is high only after `dmack_n` has been seen low in the current burst and before the burst finishes. It is low while the request waits for acknowledge and after the release.
- R5: While `rd_n` is low, `dd_o` carries the next word of the stream, in the order the words were accepted.
- R6: `phase` is low while a strobe is awaited, high from the moment a word is driven until the next strobe may begin, and low once the burst ends.
- R7: A loaded count of N yields exactly N+1 words on the bus.
- R8: If no next word is available when the strobe rises with words still owed, the engine stalls. During the stall `dmarq` and `phase` stay high, `dd_o` keeps the last word, and no stale word is sent.
- R9: `done` is a single-cycle pulse. It is raised only after `dmarq` is low and `dmack_n` has been seen high again.
- R10: The engine accepts no more than N+1 words from the stream per burst. Words beyond that stay in the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_valid | input | 1 | Transfer count offered |
| cnt_ready | output | 1 | Engine idle, count accepted |
| cnt_data | input | CNT_W | Transfer count (N gives N+1 words) |
| wd_valid | input | 1 | Stream word offered |
| wd_ready | output | 1 | Engine takes a stream word |
| wd_data | input | DW | Stream word |
| dmarq | output | 1 | DMA request to host, active high |
| dmack_n | input | 1 | DMA acknowledge from host, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| dd_o | output | DW | Data driven toward the bus |
| dd_oe | output | 1 | Output enable for the data lines |
| phase | output | 1 | Low while awaiting a strobe, high after a word is driven |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with a 16-bit word, a 4-bit count and a two-stage synchronizer. The narrow count makes the zero-count single-word burst and several multi-word bursts quick to reach. Running bursts back to back checks that a word left over from one burst becomes the next burst's prefetch. Withholding stream words reaches the count-before-data wait and a mid-burst stall.

// File: rtl/dmard_pkg.sv
// dmard_pkg: shared state encoding for the DMA burst read engine.
// Assumes: nothing beyond IEEE 1800-2017.
package dmard_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for a transfer count
        ST_PREFETCH,  // fetching the first word
        ST_REQ,       // request raised, awaiting acknowledge
        ST_STRB_LO,   // awaiting read strobe low
        ST_STRB_HI,   // word driven, awaiting strobe high
        ST_RELEASE,   // request dropped, awaiting acknowledge release
        ST_DONE       // completion pulse
    } dmard_state_e;
endpackage

// File: rtl/dmard_sync.sv
// dmard_sync: per-bit flop chain that brings asynchronous host lines into
// the clock domain. Assumes STAGES >= 2; RST_VAL gives each bit's idle level.
module dmard_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // shift the raw level through the chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/dmard_word.sv
// dmard_word: holds the next word to send and the word on the data lines.
// Assumes the controller never asks to present a word that is not held
// and never takes a new word while one is held.
module dmard_word #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,     // stream handshake completes
    input  logic [DW-1:0] wd_data,
    input  logic          present,  // move held word onto the data lines
    output logic          held_vld,
    output logic [DW-1:0] dd_q
);
    logic [DW-1:0] held;

    // capture stream words and hand them to the bus register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held     <= '0;
            held_vld <= 1'b0;
            dd_q     <= '0;
        end else begin
            if (present) begin
                dd_q     <= held;
                held_vld <= 1'b0;
            end
            if (take) begin
                held     <= wd_data;
                held_vld <= 1'b1;
            end
        end
    end

    assert_no_stale_R8: assert property (@(posedge clk) disable iff (!rst_n)
        present |-> held_vld);
    assert_single_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !held_vld);
endmodule

// File: rtl/dmard_ctrl.sv
// dmard_ctrl: burst sequencer. Loads the count, prefetches, requests,
// serves one word per strobe low/high cycle, then releases and reports.
// Assumes ack_s and rd_lo are already synchronized.
module dmard_ctrl
    import dmard_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_valid,
    input  logic [CNT_W-1:0] cnt_data,
    output logic             cnt_ready,
    input  logic             held_vld,
    output logic             wd_ready,
    input  logic             ack_s,
    input  logic             rd_lo,
    output logic             present,
    output logic             dmarq,
    output logic             dd_oe,
    output logic             phase,
    output logic             done
);
    dmard_state_e     state;
    logic [CNT_W-1:0] remain;
    logic             load;
    logic             owed;

    assign owed      = (remain != '0);
    assign load      = (state == ST_IDLE) && cnt_valid;
    assign cnt_ready = (state == ST_IDLE);
    assign present   = (state == ST_STRB_LO) && rd_lo;
    assign dmarq     = (state == ST_REQ) || (state == ST_STRB_LO) || (state == ST_STRB_HI);
    assign dd_oe     = (state == ST_STRB_LO) || (state == ST_STRB_HI);
    assign phase     = (state == ST_STRB_HI);
    assign done      = (state == ST_DONE);

    // fetch request: first word, or the following word while words are owed
    always_comb begin
        wd_ready = 1'b0;
        if (state == ST_PREFETCH)                wd_ready = !held_vld;
        else if (state == ST_STRB_HI && owed)    wd_ready = !held_vld;
    end

    // state and remaining-count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
        end else begin
            case (state)
                ST_IDLE:     if (cnt_valid) begin
                                 remain <= cnt_data;
                                 state  <= ST_PREFETCH;
                             end
                ST_PREFETCH: if (held_vld) state <= ST_REQ;
                ST_REQ:      if (ack_s) state <= ST_STRB_LO;
                ST_STRB_LO:  if (rd_lo) state <= ST_STRB_HI;
                ST_STRB_HI:  if (!rd_lo) begin
                                 if (!owed) state <= ST_RELEASE;
                                 else if (held_vld) begin
                                     remain <= remain - 1'b1;
                                     state  <= ST_STRB_LO;
                                 end
                             end
                ST_RELEASE:  if (!ack_s) state <= ST_DONE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    assert_oe_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dd_oe) |-> $past(ack_s));
    assert_done_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(!dmarq) && $past(!ack_s)));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(remain) && !$past(load)) |-> (remain == $past(remain) - 1'b1));
    assert_phase_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase) |-> $past(rd_lo));
endmodule

// File: rtl/dmard_engine.sv
// dmard_engine: top of the DMA burst read engine. Synchronizes the host
// strobe and acknowledge, then ties the sequencer to the word holder.
// Assumes the host keeps dmack_n low for the whole burst.
module dmard_engine #(
    parameter int DW          = 16,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_valid,
    output logic             cnt_ready,
    input  logic [CNT_W-1:0] cnt_data,
    input  logic             wd_valid,
    output logic             wd_ready,
    input  logic [DW-1:0]    wd_data,
    output logic             dmarq,
    input  logic             dmack_n,
    input  logic             rd_n,
    output logic [DW-1:0]    dd_o,
    output logic             dd_oe,
    output logic             phase,
    output logic             done
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] raw_lines, sync_lines;
    logic             ack_s, rd_lo, present, held_vld, fetch_req;

    assign raw_lines = {rd_n, dmack_n};
    assign ack_s     = !sync_lines[0];
    assign rd_lo     = !sync_lines[1];
    assign wd_ready  = fetch_req;

    dmard_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL('1)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
    );

    dmard_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cnt_valid(cnt_valid), .cnt_data(cnt_data), .cnt_ready(cnt_ready),
        .held_vld(held_vld), .wd_ready(fetch_req),
        .ack_s(ack_s), .rd_lo(rd_lo), .present(present),
        .dmarq(dmarq), .dd_oe(dd_oe), .phase(phase), .done(done)
    );

    dmard_word #(.DW(DW)) word_i (
        .clk(clk), .rst_n(rst_n),
        .take(wd_valid && fetch_req), .wd_data(wd_data),
        .present(present), .held_vld(held_vld), .dd_q(dd_o)
    );

    assert_req_low_until_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmarq) |-> $past(held_vld));
endmodule

// File: tb/dmard_engine_tb_top.sv
// Scoreboard bench: push_word queues a stream word and its expected bus
// value; the host model pops and compares on every strobe.
module dmard_engine_tb_top;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_valid = 1'b0;
    logic [CW-1:0] cnt_data = '0;
    logic          wd_valid = 1'b0;
    logic [DW-1:0] wd_data = '0;
    logic          dmack_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          cnt_ready, wd_ready, dmarq, dd_oe, phase, done;
    logic [DW-1:0] dd_o;

    int n_checks = 0, n_fail = 0, done_cnt = 0;
    logic [DW-1:0] src_q[$];
    logic [DW-1:0] exp_q[$];
    bit src_en = 1'b1;

    always #5 clk = ~clk;

    dmard_engine #(.DW(DW), .CNT_W(CW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cnt_valid(cnt_valid), .cnt_ready(cnt_ready), .cnt_data(cnt_data),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .dmarq(dmarq), .dmack_n(dmack_n), .rd_n(rd_n),
        .dd_o(dd_o), .dd_oe(dd_oe), .phase(phase), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_word(input logic [DW-1:0] w);
        src_q.push_back(w);
        exp_q.push_back(w);
    endtask

    // stream source: pops after a completed handshake, then re-offers
    bit hs_pend = 1'b0;
    always @(negedge clk) begin
        if (hs_pend) void'(src_q.pop_front());
        wd_valid = src_en && (src_q.size() > 0);
        wd_data  = (src_q.size() > 0) ? src_q[0] : '0;
        hs_pend  = wd_valid && wd_ready;
    end

    always @(negedge clk) if (rst_n && done) done_cnt++;

    task automatic give_count(input logic [CW-1:0] n);
        bit hs;
        cnt_data  = n;
        cnt_valid = 1'b1;
        do begin
            hs = cnt_ready;
            @(negedge clk);
        end while (!hs);
        cnt_valid = 1'b0;
    endtask

    task automatic wait_req;
        for (int i = 0; i < 60 && !dmarq; i++) @(negedge clk);
        check(dmarq == 1'b1, "R3 request raised", dmarq, 1);
    endtask

    // host side of one burst; stall_idx < 0 means no stall test
    task automatic host_burst(input int n_words, input int stall_idx, input int late);
        logic [DW-1:0] e;
        int d0;
        repeat (3) @(negedge clk);
        check(dd_oe == 1'b0, "R4 no drive before ack", dd_oe, 0);
        dmack_n = 1'b0;
        for (int i = 0; i < n_words; i++) begin
            repeat (4) @(negedge clk);
            check(phase == 1'b0, "R6 phase low awaiting strobe", phase, 0);
            rd_n = 1'b0;
            repeat (5) @(negedge clk);
            e = exp_q.pop_front();
            check(dd_o == e, "R5 word on strobe", dd_o, e);
            check(dd_oe == 1'b1, "R4 drive during burst", dd_oe, 1);
            check(phase == 1'b1, "R6 phase high after drive", phase, 1);
            rd_n = 1'b1;
            repeat (5) @(negedge clk);
            if (i < n_words - 1)
                check(dmarq == 1'b1, "R3 request held mid-burst", dmarq, 1);
            if (i == stall_idx) begin
                repeat (10) @(negedge clk);
                check(dmarq && phase, "R8 stall holds request and phase", {dmarq, phase}, 3);
                check(dd_o == e, "R8 no stale word", dd_o, e);
                for (int k = 0; k < late; k++) push_word(16'hC000 + 16'(k));
                repeat (3) @(negedge clk);
            end
        end
        d0 = done_cnt;
        check(dmarq == 1'b0, "R3 request dropped at end", dmarq, 0);
        check(dd_oe == 1'b0, "R4 drive off at end", dd_oe, 0);
        check(phase == 1'b0, "R6 phase low at end", phase, 0);
        repeat (6) @(negedge clk);
        check(done_cnt == d0, "R9 no done while ack held", done_cnt, d0);
        dmack_n = 1'b1;
        repeat (8) @(negedge clk);
        check(done_cnt == d0 + 1, "R9 single done pulse", done_cnt, d0 + 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!dmarq && !dd_oe && !phase && !done, "R1 outputs idle in reset",
              {dmarq, dd_oe, phase, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cnt_ready == 1'b1, "R1 ready after reset", cnt_ready, 1);

        // burst A: count 2 -> 3 words; count arrives before any data
        give_count(4'd2);
        check(cnt_ready == 1'b0, "R2 count not taken while busy", cnt_ready, 0);
        repeat (10) @(negedge clk);
        check(dmarq == 1'b0, "R2 no request before first word", dmarq, 0);
        push_word(16'h1111); push_word(16'h2222);
        push_word(16'h3333); push_word(16'h4444);
        wait_req();
        host_burst(3, -1, 0);
        check(src_q.size() == 1, "R10 R7 extra word left in source", src_q.size(), 1);
        check(exp_q.size() == 1, "R7 three words consumed", exp_q.size(), 1);

        // burst B: count 3 -> 4 words, stall after the second word
        push_word(16'h5555);
        give_count(4'd3);
        wait_req();
        host_burst(4, 1, 2);
        check(src_q.size() == 0 && exp_q.size() == 0, "R7 four words consumed",
              src_q.size(), 0);

        // burst C: count 0 -> a single word
        push_word(16'hBEEF); push_word(16'hF00D);
        give_count(4'd0);
        wait_req();
        host_burst(1, -1, 0);
        check(src_q.size() == 1, "R10 R7 zero count takes one word", src_q.size(), 1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule